// File: doc/BRIEF.md
# Multi-State Instruction Fetch Aligner

This block sits between a 32-bit memory read port and an instruction decoder. It always reads aligned 32-bit words, keeps the word in a buffer and hands the decoder one instruction per handshake. The width of each instruction depends on the execution mode. Word mode yields one 32-bit instruction from each word. Halfword mode yields two 16-bit instructions. Byte mode yields four 8-bit bytecodes. Within a word, instructions go out lowest address first. Each one is zero-extended onto a 32-bit output and comes with its own address and mode.

A redirect input carries a target address and a byte-mode flag. It changes the mode and discards the buffered word. The next read then starts at the target, and output resumes at the target's offset inside that word. The memory side has a sequential flag. It is high only when the requested word directly follows the previous read with no redirect in between.

The controller has two named states. In FETCH it requests a word. In ISSUE it holds the word and offers slices of it. The transitions are:
- FETCH to ISSUE on a memory acknowledge.
- ISSUE stays in ISSUE after each consumed instruction that is not the last one in the word.
- ISSUE to FETCH once the last instruction in the word is consumed.
- Any state to FETCH on a redirect.

Top module: `fetch_aligner`

## Requirements
- R1: On reset the block is in FETCH and requests the word at RESET_ADDR with the two low bits cleared. Its mode is word (out_mode = 0), mem_seq is low and out_valid is low.
- R2: While mem_req is high, mem_addr[1:0] is 0.
- R3: In word mode (out_mode = 0), out_instr is the whole fetched word and out_pc advances by 4 per consumed instruction.
- R4: In halfword mode (out_mode = 1), offset 0 gives word bits 15:0 and offset 2 gives bits 31:16. Both are zero-extended and out_pc advances by 2.
- R5: In byte mode (out_mode = 2), offset k gives word bits 8k+7:8k, zero-extended, and out_pc advances by 1.
- R6: A new read is requested only after the last instruction of the buffered word is consumed, or after a redirect. mem_req and out_valid are never high together.
- R7: mem_seq is high exactly when the requested address equals the previous accepted read address plus 4 and no redirect has occurred since that read. It is low for the first read after reset and after every redirect.
- R8: On a redirect with br_byte = 1, the mode becomes byte and the target is used unchanged. Otherwise br_target[0] = 1 selects halfword mode with bit 0 cleared, and br_target[0] = 0 selects word mode with bits 1:0 cleared. These ignored low bits never show up in out_pc.
- R9: After a redirect into the middle of a word, the first instruction emitted is the one at the target offset.
- R10: While out_valid is high and out_ready is low (with no redirect), out_valid, out_instr and out_pc hold steady on the next cycle.
- R11: A redirect in the same cycle as a consume or a memory acknowledge takes priority. The consumed instruction does not advance the address, the acknowledged data is dropped, and output continues from the target.
- R12: In the cycle after a redirect, out_valid is low and a non-sequential read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Word-aligned read address |
| mem_seq | output | 1 | Requested address follows the previous read |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| br_valid | input | 1 | Redirect strobe |
| br_target | input | ADDR_W | Redirect target; bit 0 selects halfword mode when br_byte is low |
| br_byte | input | 1 | Redirect into byte mode |
| out_valid | output | 1 | Instruction available |
| out_ready | input | 1 | Decoder accepts the instruction |
| out_instr | output | 32 | Instruction, zero-extended |
| out_pc | output | ADDR_W | Address of the instruction |
| out_mode | output | 2 | Mode of the instruction: 0 word, 1 halfword, 2 byte |

## Verification
There are two coincidences that matter. A redirect can land in the same cycle as a decoder handshake, and a redirect can land in the same cycle as a memory acknowledge. The stimulus drives random redirects against random ready and acknowledge patterns, and it also forces each of these coincidences directly. The bench keeps an expected address and mode. It lets the redirect override any handshake in that cycle, and then compares every emitted instruction, address and mode, as well as every requested address and the sequential flag, with this model.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [1:0] {
        MODE_WORD = 2'd0,
        MODE_HALF = 2'd1,
        MODE_BYTE = 2'd2
    } exec_mode_t;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_ISSUE = 1'b1
    } fetch_state_t;

    function automatic logic [2:0] step_of(exec_mode_t m);
        unique case (m)
            MODE_WORD: return 3'd4;
            MODE_HALF: return 3'd2;
            default:   return 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/fa_slicer.sv
module fa_slicer
    import fa_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        off,
    input  exec_mode_t        mode,
    output logic [WORD_W-1:0] instr
);
    localparam int HALF_W = WORD_W / 2;
    localparam int LANES  = WORD_W / 8;

    logic [7:0] lane [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane[g] = word[8*g +: 8];
        end
    endgenerate

    always_comb begin
        instr = '0;
        unique case (mode)
            MODE_WORD: instr = word;
            MODE_HALF: instr[HALF_W-1:0] = off[1] ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
            default:   instr[7:0] = lane[off];
        endcase
    end
endmodule

// File: rtl/fa_redirect.sv
module fa_redirect
    import fa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] target,
    input  logic              to_byte,
    output logic [ADDR_W-1:0] new_pc,
    output exec_mode_t        new_mode
);
    always_comb begin
        if (to_byte) begin
            new_mode = MODE_BYTE;
            new_pc   = target;
        end else if (target[0]) begin
            new_mode = MODE_HALF;
            new_pc   = {target[ADDR_W-1:1], 1'b0};
        end else begin
            new_mode = MODE_WORD;
            new_pc   = {target[ADDR_W-1:2], 2'b00};
        end
    end
endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
    import fa_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              WORD_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_pc,
    input  exec_mode_t        br_mode,
    input  logic              out_ready,
    output fetch_state_t      state,
    output logic [ADDR_W-1:0] pc_q,
    output exec_mode_t        mode_q,
    output logic              seq_q,
    output logic [WORD_W-1:0] buf_q
);
    fetch_state_t state_nx;
    logic [2:0]   step;
    logic [2:0]   slot_end;
    logic         last_slot;

    assign step      = step_of(mode_q);
    assign slot_end  = {1'b0, pc_q[1:0]} + step;
    assign last_slot = slot_end[2];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (br_valid) begin
            state_nx = ST_FETCH;
        end else begin
            unique case (state)
                ST_FETCH: if (mem_ack) state_nx = ST_ISSUE;
                ST_ISSUE: if (out_ready && last_slot) state_nx = ST_FETCH;
                default:  state_nx = ST_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RESET_ADDR;
            mode_q <= MODE_WORD;
            seq_q  <= 1'b0;
            buf_q  <= '0;
        end else if (br_valid) begin
            pc_q   <= br_pc;
            mode_q <= br_mode;
            seq_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_FETCH: if (mem_ack) buf_q <= mem_rdata;
                ST_ISSUE: if (out_ready) begin
                    pc_q <= pc_q + ADDR_W'(step);
                    if (last_slot) seq_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_seq,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              br_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_instr,
    output logic [ADDR_W-1:0] out_pc,
    output logic [1:0]        out_mode
);
    localparam int WORD_W = 32;

    fetch_state_t      state;
    logic [ADDR_W-1:0] pc_q;
    exec_mode_t        mode_q;
    logic              seq_q;
    logic [WORD_W-1:0] buf_q;
    logic [ADDR_W-1:0] br_pc;
    exec_mode_t        br_mode;

    fa_redirect #(.ADDR_W(ADDR_W)) u_redirect (
        .target  (br_target),
        .to_byte (br_byte),
        .new_pc  (br_pc),
        .new_mode(br_mode)
    );

    fa_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RESET_ADDR(RESET_ADDR)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .br_valid (br_valid),
        .br_pc    (br_pc),
        .br_mode  (br_mode),
        .out_ready(out_ready),
        .state    (state),
        .pc_q     (pc_q),
        .mode_q   (mode_q),
        .seq_q    (seq_q),
        .buf_q    (buf_q)
    );

    fa_slicer #(.WORD_W(WORD_W)) u_slicer (
        .word (buf_q),
        .off  (pc_q[1:0]),
        .mode (mode_q),
        .instr(out_instr)
    );

    always_comb begin
        mem_req   = (state == ST_FETCH);
        mem_addr  = {pc_q[ADDR_W-1:2], 2'b00};
        mem_seq   = (state == ST_FETCH) && seq_q;
        out_valid = (state == ST_ISSUE);
        out_pc    = pc_q;
        out_mode  = mode_q;
    end
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_seq,
    input logic              br_valid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [31:0]       out_instr,
    input logic [ADDR_W-1:0] out_pc,
    input logic [1:0]        out_mode
);
    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R6
    no_fetch_while_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && out_valid));

    // R3
    word_pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 2'd0) |-> out_pc[1:0] == 2'b00);

    // R4
    half_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 2'd1) |-> (out_instr[31:16] == 16'h0 && !out_pc[0]));

    // R5
    byte_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 2'd2) |-> out_instr[31:8] == 24'h0);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !br_valid) |=>
            (out_valid && $stable(out_instr) && $stable(out_pc)));

    // R12
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (!out_valid && mem_req && !mem_seq));
endmodule

bind fetch_aligner fa_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fetch_aligner_test.sv
module fetch_aligner_test;
    localparam logic [31:0] RST_A = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_req, mem_seq, mem_ack;
    logic [31:0] mem_addr, mem_rdata;
    logic        br_valid, br_byte;
    logic [31:0] br_target;
    logic        out_valid, out_ready;
    logic [31:0] out_instr, out_pc;
    logic [1:0]  out_mode;

    always #10 clk = ~clk;

    fetch_aligner #(.ADDR_W(32), .RESET_ADDR(RST_A)) uut (.*);

    function automatic logic [31:0] memfn(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    assign mem_rdata = memfn(mem_addr);

    function automatic logic [31:0] exp_slice(logic [31:0] a, logic [1:0] m);
        logic [31:0] w;
        w = memfn({a[31:2], 2'b00});
        case (m)
            2'd0:    return w;
            2'd1:    return a[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
            default: return (w >> (8 * a[1:0])) & 32'hFF;
        endcase
    endfunction

    int compared = 0;
    int mismatched = 0;
    int idle_cycles = 0;
    logic [31:0] e_pc, prev_fa;
    logic [1:0]  e_mode;
    logic        seq_ok, prev_br, prev_stall, after_br, br_coinc;
    logic [31:0] held_instr, held_pc;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic bv, input logic [31:0] bt, input logic bb,
                         input logic rdy, input logic ack);
        logic fire;
        string tg;
        br_valid = bv; br_target = bt; br_byte = bb; out_ready = rdy; mem_ack = ack;
        #1;
        chk(!(mem_req && out_valid), "R6", {30'b0, mem_req, out_valid}, 32'h0);
        if (prev_br)
            chk(!out_valid && mem_req && !mem_seq, "R12", {29'b0, out_valid, mem_req, mem_seq}, 32'h2);
        if (prev_stall && !prev_br) begin
            chk(out_valid, "R10", {31'b0, out_valid}, 32'h1);
            chk(out_instr == held_instr && out_pc == held_pc, "R10", out_instr, held_instr);
        end
        if (mem_req) begin
            chk(mem_addr[1:0] == 2'b00, "R2", mem_addr, {mem_addr[31:2], 2'b00});
            chk(mem_addr == {e_pc[31:2], 2'b00}, "R6", mem_addr, {e_pc[31:2], 2'b00});
            chk(mem_seq == (seq_ok && mem_addr == prev_fa + 32'd4), "R7",
                {31'b0, mem_seq}, {31'b0, seq_ok && mem_addr == prev_fa + 32'd4});
        end
        if (out_valid) begin
            tg = (e_mode == 2'd0) ? "R3" : (e_mode == 2'd1) ? "R4" : "R5";
            if (after_br) tg = br_coinc ? "R11" : (e_pc[1:0] != 2'b00 ? "R9" : "R8");
            chk(out_pc == e_pc && out_mode == e_mode, tg, out_pc, e_pc);
            chk(out_instr == exp_slice(e_pc, e_mode), tg, out_instr, exp_slice(e_pc, e_mode));
        end
        fire = out_valid && rdy && !bv;
        prev_stall = out_valid && !rdy && !bv;
        held_instr = out_instr; held_pc = out_pc;
        if (bv) begin
            br_coinc = (out_valid && rdy) || (mem_req && ack);
            after_br = 1'b1;
            seq_ok = 1'b0;
            if (bb) begin e_mode = 2'd2; e_pc = bt; end
            else if (bt[0]) begin e_mode = 2'd1; e_pc = {bt[31:1], 1'b0}; end
            else begin e_mode = 2'd0; e_pc = {bt[31:2], 2'b00}; end
        end else begin
            if (mem_req && ack) begin prev_fa = mem_addr; seq_ok = 1'b1; end
            if (fire) begin
                after_br = 1'b0;
                e_pc = e_pc + ((e_mode == 2'd0) ? 32'd4 : (e_mode == 2'd1) ? 32'd2 : 32'd1);
            end
        end
        prev_br = bv;
        idle_cycles = fire ? 0 : idle_cycles + 1;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd12345));
        rst_n = 1'b0; br_valid = 0; br_target = 0; br_byte = 0; out_ready = 0; mem_ack = 0;
        e_pc = RST_A; e_mode = 2'd0; prev_fa = 0; seq_ok = 0; prev_br = 0; prev_stall = 0;
        after_br = 0; br_coinc = 0; held_instr = 0; held_pc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(mem_req && mem_addr == RST_A && !mem_seq, "R1", mem_addr, RST_A);
        chk(!out_valid && out_mode == 2'd0, "R1", {30'b0, out_mode}, 32'h0);

        // R3 linear word stream, R7 sequential refetch
        repeat (12) cycle(0, 0, 0, 1, 1);
        // R8/R9 halfword redirect into upper half, bit 0 ignored
        cycle(1, 32'h0000_1003, 0, 1, 1);
        repeat (10) cycle(0, 0, 0, 1, 1);
        // R5/R9 byte redirect onto last byte of a word
        cycle(1, 32'h0000_2003, 1, 1, 1);
        repeat (12) cycle(0, 0, 0, 1, 1);
        // R8 word redirect with bit 1 set, cleared
        cycle(1, 32'h0000_3002, 0, 1, 0);
        repeat (6) cycle(0, 0, 0, 0, 1);
        // R11 redirect coincident with a consume
        cycle(1, 32'h0000_4001, 0, 1, 1);
        // R11 redirect coincident with an acknowledge (block is in FETCH now)
        cycle(1, 32'h0000_5002, 1, 1, 1);
        repeat (8) cycle(0, 0, 0, 1, 1);

        for (int i = 0; i < 6000 && idle_cycles < 500; i++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(($urandom % 32) == 0, {16'h0, r[15:0]}, ($urandom % 3) == 0,
                  ($urandom % 10) < 7, ($urandom % 10) < 6);
        end
        if (idle_cycles >= 500) chk(1'b0, "watchdog", idle_cycles, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule